// File: doc/BRIEF.md
# Load/Store Alignment Unit

This unit sits between the memory stage of a processor pipeline and a data memory that is one 32-bit word wide. It takes one access request at a time: a byte address, an access size, a read/write flag, a sign-extension flag and the write data. It turns the request into one or two word-aligned memory beats. For a read it selects, merges and extends the requested bytes into a 32-bit result. For a write it places the data into the correct byte lanes and drives matching byte enables.

A 2-bit policy input decides what happens when a halfword or word is not aligned to its own size. Under the clip policy, the offending low address bits are cleared and one beat is issued. Under the trap policy, no beat is issued and a fault is returned. Under the stitch policy, the access runs as two consecutive word beats whenever it straddles a word boundary, and the pieces are joined. Each memory beat is held until the memory raises its ready input. Every request ends with a one-cycle completion pulse. A following request can be taken in that same cycle.

Top module: `lsa_top`

## Requirements
- R1: The size code `req_size` is 00 for byte, 01 for halfword and 10 for word, and 11 acts as word. A halfword is aligned when address bit 0 is clear. A word is aligned when address bits 1:0 are clear. A byte is always aligned and is never faulted or split, under any policy.
- R2: An aligned access issues exactly one beat at `mem_addr` = address with bits 1:0 cleared. The access completes without fault.
- R3: With `policy` = 00 (clip), a misaligned halfword is performed as if address bit 0 were 0. A misaligned word is performed as if address bits 1:0 were 0. In both cases one beat is issued and no fault is raised.
- R4: With `policy` = 01 or 11 (trap), a misaligned access issues no beat. It completes with `fault` = 1 and `rdata` = 0.
- R5: With `policy` = 10 (stitch), a misaligned access whose last byte falls in the next word issues two beats. The first beat goes to the lower word address and the second to that address plus 4. A misaligned access that stays inside one word, such as a halfword at offset 1, issues one beat.
- R6: A load result is zero-extended when `req_signed` = 0. When `req_signed` = 1, a byte is extended from bit 7 and a halfword from bit 15. A word is returned as read.
- R7: Byte order is little-endian. The byte at the lowest accessed address lands in `rdata[7:0]`. For a two-beat load, the bytes taken from the second word follow those from the first.
- R8: On each beat, `mem_be` bit k is set exactly when byte lane k holds a byte of the access. `mem_wdata` carries the store data shifted into those lanes, and every other lane is zero.
- R9: `done` is asserted for one cycle, in the cycle after the handshake of the last beat (for a trapped access, in the cycle after acceptance). `req_ready` is high when idle and during `done`, so a new request can be accepted in the completion cycle.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be` and `mem_wdata` hold their values.
- R11: A synchronous reset returns the unit to idle: `mem_valid` = 0, `done` = 0, `fault` = 0, `rdata` = 0 and `req_ready` = 1, even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend a load result |
| req_wdata | input | 32 | Store data, right-aligned |
| policy | input | 2 | Misalignment policy |
| mem_valid | output | 1 | Memory beat request |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_write | output | 1 | Beat is a write |
| mem_be | output | 4 | Byte enables of the beat |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_ready | input | 1 | Memory accepts / completes the beat |
| mem_rdata | input | 32 | Word read by the beat |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Completion is an alignment fault |
| rdata | output | 32 | Load result, valid with done |

## Verification
The completion pulse of one request and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting a second request in the very cycle where `done` for a two-beat stitched load is high. It then judges three things: the first result is intact in that cycle, the second request's beat starts on the next cycle, and the second result and beat address are correct. The vector table is also replayed with a stalling memory, so that the second beat of a split access and the hold rule are exercised under wait states.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int LB_W   = $clog2(LANE_W);
    localparam int SH_W   = $clog2(2 * WORD_W);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        POL_CLIP     = 2'b00,
        POL_TRAP     = 2'b01,
        POL_STITCH   = 2'b10,
        POL_TRAP_ALT = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_RESP
    } seq_st_e;

    typedef struct packed {
        logic             fault;
        logic             split;
        logic [OFF_W-1:0] off;
    } plan_t;

    function automatic logic [OFF_W:0] size_bytes(size_e s);
        case (s)
            SZ_BYTE: return (OFF_W+1)'(1);
            SZ_HALF: return (OFF_W+1)'(2);
            default: return (OFF_W+1)'(LANES);
        endcase
    endfunction

    function automatic logic [LANES-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: return LANES'(1);
            SZ_HALF: return LANES'(3);
            default: return {LANES{1'b1}};
        endcase
    endfunction

    // Offset bits that survive clipping for a given size.
    function automatic logic [OFF_W-1:0] keep_mask(size_e s);
        return ~OFF_W'(size_bytes(s) - (OFF_W+1)'(1));
    endfunction

endpackage

// File: rtl/lsa_classify.sv
module lsa_classify
    import lsa_pkg::*;
(
    input  size_e            size,
    input  policy_e          pol,
    input  logic [OFF_W-1:0] low,
    output plan_t            plan
);

    logic [OFF_W-1:0] keep;
    logic             misal;
    logic [OFF_W:0]   last_pos;
    logic             crosses;

    always_comb begin
        keep     = keep_mask(size);
        misal    = (low & ~keep) != '0;
        last_pos = {1'b0, low} + size_bytes(size) - (OFF_W+1)'(1);
        crosses  = last_pos[OFF_W];
        plan     = '0;
        case (pol)
            POL_CLIP: begin
                plan.off = low & keep;
            end
            POL_STITCH: begin
                plan.off   = low;
                plan.split = misal && crosses;
            end
            default: begin
                plan.off   = low;
                plan.fault = misal;
            end
        endcase
    end

endmodule

// File: rtl/lsa_lanes.sv
module lsa_lanes
    import lsa_pkg::*;
(
    input  size_e             size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sgn,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output logic [LANES-1:0]  be_lo,
    output logic [LANES-1:0]  be_hi,
    output logic [WORD_W-1:0] wd_lo,
    output logic [WORD_W-1:0] wd_hi,
    output logic [WORD_W-1:0] ld_val
);

    logic [LANES-1:0]    m;
    logic [WORD_W-1:0]   wmask;
    logic [SH_W-1:0]     sh;
    logic [2*LANES-1:0]  be2;
    logic [2*WORD_W-1:0] wd2;
    logic [2*WORD_W-1:0] win;
    logic [WORD_W-1:0]   raw;
    logic                sbit;

    always_comb begin
        m = size_mask(size);
        for (int l = 0; l < LANES; l++) begin
            wmask[l*LANE_W +: LANE_W] = {LANE_W{m[l]}};
        end
        sh  = SH_W'(off) << LB_W;
        // store side: lanes across a two-word window
        be2 = {{LANES{1'b0}}, m} << off;
        wd2 = {{WORD_W{1'b0}}, wdata & wmask} << sh;
        be_lo = be2[LANES-1:0];
        be_hi = be2[2*LANES-1:LANES];
        wd_lo = wd2[WORD_W-1:0];
        wd_hi = wd2[2*WORD_W-1:WORD_W];
        // load side: slide the window down to lane 0, then extend
        win = {hi_word, lo_word} >> sh;
        raw = win[WORD_W-1:0];
        case (size)
            SZ_BYTE: sbit = raw[LANE_W-1];
            SZ_HALF: sbit = raw[2*LANE_W-1];
            default: sbit = raw[WORD_W-1];
        endcase
        ld_val = (raw & wmask) | ((sgn && sbit) ? ~wmask : '0);
    end

endmodule

// File: rtl/lsa_seq.sv
module lsa_seq
    import lsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic in_fault,
    input  logic cur_split,
    input  logic mem_ready,
    output logic req_ready,
    output logic accept,
    output logic mem_valid,
    output logic beat_hi,
    output logic lo_cap,
    output logic fin,
    output logic done
);

    seq_st_e st, st_nx;

    always_comb begin
        req_ready = (st == ST_IDLE) || (st == ST_RESP);
        accept    = req_ready && req_valid;
        mem_valid = (st == ST_FIRST) || (st == ST_SECOND);
        beat_hi   = (st == ST_SECOND);
        lo_cap    = (st == ST_FIRST) && mem_ready && cur_split;
        fin       = mem_valid && mem_ready && (beat_hi || !cur_split);
        done      = (st == ST_RESP);
        st_nx     = st;
        case (st)
            ST_FIRST:  if (mem_ready) st_nx = cur_split ? ST_SECOND : ST_RESP;
            ST_SECOND: if (mem_ready) st_nx = ST_RESP;
            default: begin
                if (accept) st_nx = in_fault ? ST_RESP : ST_FIRST;
                else        st_nx = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // R5: the upper beat is only entered after the lower beat completed
    a_r5_second_follows_first: assert property (@(posedge clk) disable iff (rst)
        $rose(beat_hi) |-> $past(mem_valid && mem_ready && !beat_hi));

endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_signed,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        policy,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [31:0]       rdata
);

    localparam int IDX_W = ADDR_W - OFF_W;

    size_e   in_size;
    policy_e in_pol;
    plan_t   in_plan;

    logic [IDX_W-1:0]  widx_q;
    size_e             size_q;
    logic              wr_q, sgn_q;
    logic [WORD_W-1:0] wdata_q, lo_q, rdata_q;
    plan_t             plan_q;

    logic accept, beat_hi, lo_cap, fin;
    logic [LANES-1:0]  be_lo, be_hi;
    logic [WORD_W-1:0] wd_lo, wd_hi, ld_val, lo_in, hi_in;

    assign in_size = size_e'(req_size);
    assign in_pol  = policy_e'(policy);

    lsa_classify u_cls (
        .size (in_size),
        .pol  (in_pol),
        .low  (req_addr[OFF_W-1:0]),
        .plan (in_plan)
    );

    lsa_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .in_fault  (in_plan.fault),
        .cur_split (plan_q.split),
        .mem_ready (mem_ready),
        .req_ready (req_ready),
        .accept    (accept),
        .mem_valid (mem_valid),
        .beat_hi   (beat_hi),
        .lo_cap    (lo_cap),
        .fin       (fin),
        .done      (done)
    );

    assign lo_in = plan_q.split ? lo_q : mem_rdata;
    assign hi_in = plan_q.split ? mem_rdata : '0;

    lsa_lanes u_lanes (
        .size    (size_q),
        .off     (plan_q.off),
        .sgn     (sgn_q),
        .wdata   (wdata_q),
        .lo_word (lo_in),
        .hi_word (hi_in),
        .be_lo   (be_lo),
        .be_hi   (be_hi),
        .wd_lo   (wd_lo),
        .wd_hi   (wd_hi),
        .ld_val  (ld_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            widx_q  <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            sgn_q   <= 1'b0;
            wdata_q <= '0;
            plan_q  <= '0;
            lo_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                widx_q  <= req_addr[ADDR_W-1:OFF_W];
                size_q  <= in_size;
                wr_q    <= req_write;
                sgn_q   <= req_signed;
                wdata_q <= req_wdata;
                plan_q  <= in_plan;
                if (in_plan.fault) rdata_q <= '0;
            end
            if (lo_cap) lo_q <= mem_rdata;
            if (fin)    rdata_q <= wr_q ? '0 : ld_val;
        end
    end

    assign mem_addr  = {widx_q + {{(IDX_W-1){1'b0}}, beat_hi}, {OFF_W{1'b0}}};
    assign mem_write = wr_q;
    assign mem_be    = beat_hi ? be_hi : be_lo;
    assign mem_wdata = beat_hi ? wd_hi : wd_lo;
    assign fault     = done && plan_q.fault;
    assign rdata     = rdata_q;

    // R1: byte requests are never trapped or split
    a_r1_byte_single: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_size == SZ_BYTE) |-> (!in_plan.fault && !in_plan.split));

    // R4: a trapped request never reaches memory
    a_r4_trap_no_beat: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !plan_q.fault);

    // R5: the second beat addresses the following word
    a_r5_next_word: assert property (@(posedge clk) disable iff (rst)
        $rose(beat_hi) |-> (mem_addr == $past(mem_addr) + ADDR_W'(LANES)));

    // R8: a single-beat access enables exactly its own bytes
    a_r8_be_count: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !plan_q.split) |-> ($countones(mem_be) == int'(size_bytes(size_q))));

    // R9: a non-fault completion follows the final beat handshake
    a_r9_done_after_beat: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> $past(fin));

    // R10: a stalled beat keeps its request stable
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_be) && $stable(mem_wdata)));

endmodule

// File: tb/lsa_top_tb.sv
module lsa_top_tb_top;

    typedef struct packed {
        logic [1:0]  pol;
        logic [1:0]  size;
        logic        wr;
        logic        sgn;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        flt;
        logic [1:0]  nbeat;
        logic [31:0] rdata;
        logic [3:0]  be0;
        logic [3:0]  be1;
        logic [31:0] wd0;
        logic [31:0] wd1;
    } vec_t;

    localparam int NV = 21;
    // Memory model: each byte holds the low 8 bits of its own address.
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd2, 1'b0, 1'b0, 32'h100000F4, 32'h0, 1'b0, 2'd1, 32'hF7F6F5F4, 4'b1111, 4'b0000, 32'h0, 32'h0}, // R2
        '{2'd0, 2'd0, 1'b0, 1'b1, 32'h100000F5, 32'h0, 1'b0, 2'd1, 32'hFFFFFFF5, 4'b0010, 4'b0000, 32'h0, 32'h0}, // R6 byte signed
        '{2'd0, 2'd0, 1'b0, 1'b0, 32'h10000043, 32'h0, 1'b0, 2'd1, 32'h00000043, 4'b1000, 4'b0000, 32'h0, 32'h0}, // R1
        '{2'd0, 2'd1, 1'b0, 1'b1, 32'h100000F6, 32'h0, 1'b0, 2'd1, 32'hFFFFF7F6, 4'b1100, 4'b0000, 32'h0, 32'h0}, // R6 half signed
        '{2'd0, 2'd1, 1'b0, 1'b0, 32'h10000042, 32'h0, 1'b0, 2'd1, 32'h00004342, 4'b1100, 4'b0000, 32'h0, 32'h0}, // R7
        '{2'd0, 2'd2, 1'b0, 1'b0, 32'h100000F6, 32'h0, 1'b0, 2'd1, 32'hF7F6F5F4, 4'b1111, 4'b0000, 32'h0, 32'h0}, // R3 word clip
        '{2'd0, 2'd1, 1'b0, 1'b0, 32'h100000F5, 32'h0, 1'b0, 2'd1, 32'h0000F5F4, 4'b0011, 4'b0000, 32'h0, 32'h0}, // R3 half clip
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'h100000F5, 32'h0, 1'b1, 2'd0, 32'h00000000, 4'b0000, 4'b0000, 32'h0, 32'h0}, // R4
        '{2'd3, 2'd1, 1'b0, 1'b0, 32'h10000043, 32'h0, 1'b1, 2'd0, 32'h00000000, 4'b0000, 4'b0000, 32'h0, 32'h0}, // R4 code 11
        '{2'd2, 2'd2, 1'b0, 1'b0, 32'h100000F6, 32'h0, 1'b0, 2'd2, 32'hF9F8F7F6, 4'b1100, 4'b0011, 32'h0, 32'h0}, // R5
        '{2'd2, 2'd1, 1'b0, 1'b1, 32'h100000F7, 32'h0, 1'b0, 2'd2, 32'hFFFFF8F7, 4'b1000, 4'b0001, 32'h0, 32'h0}, // R5 R6
        '{2'd2, 2'd2, 1'b0, 1'b0, 32'h10000041, 32'h0, 1'b0, 2'd2, 32'h44434241, 4'b1110, 4'b0001, 32'h0, 32'h0}, // R7
        '{2'd2, 2'd1, 1'b0, 1'b0, 32'h10000041, 32'h0, 1'b0, 2'd1, 32'h00004241, 4'b0110, 4'b0000, 32'h0, 32'h0}, // R5 in-word
        '{2'd2, 2'd2, 1'b1, 1'b0, 32'h10000043, 32'hDDCCBBAA, 1'b0, 2'd2, 32'h0, 4'b1000, 4'b0111, 32'hAA000000, 32'h00DDCCBB}, // R8
        '{2'd0, 2'd0, 1'b1, 1'b0, 32'h10000042, 32'h1234565A, 1'b0, 2'd1, 32'h0, 4'b0100, 4'b0000, 32'h005A0000, 32'h0}, // R8 byte
        '{2'd1, 2'd1, 1'b1, 1'b0, 32'h10000041, 32'h0000BEEF, 1'b1, 2'd0, 32'h0, 4'b0000, 4'b0000, 32'h0, 32'h0}, // R4 store
        '{2'd0, 2'd1, 1'b1, 1'b0, 32'h10000043, 32'h1234BEEF, 1'b0, 2'd1, 32'h0, 4'b1100, 4'b0000, 32'hBEEF0000, 32'h0}, // R3 store
        '{2'd1, 2'd0, 1'b0, 1'b0, 32'h100000F7, 32'h0, 1'b0, 2'd1, 32'h000000F7, 4'b1000, 4'b0000, 32'h0, 32'h0}, // R1 trap
        '{2'd3, 2'd2, 1'b0, 1'b0, 32'h100000F4, 32'h0, 1'b0, 2'd1, 32'hF7F6F5F4, 4'b1111, 4'b0000, 32'h0, 32'h0}, // R2
        '{2'd1, 2'd1, 1'b0, 1'b1, 32'h10000046, 32'h0, 1'b0, 2'd1, 32'h00004746, 4'b1100, 4'b0000, 32'h0, 32'h0}, // R6
        '{2'd2, 2'd3, 1'b0, 1'b0, 32'h100000FF, 32'h0, 1'b0, 2'd2, 32'h020100FF, 4'b1000, 4'b0111, 32'h0, 32'h0}  // R1 code 11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_signed = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  policy = '0;
    logic        mem_valid, mem_write, mem_ready, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rdata;
    logic [3:0]  mem_be;

    int checks = 0;
    int fails  = 0;
    int cyc = 0, hs_cyc = 0, hs_total = 0, stall_cnt = 0;
    int stall_cfg = 0;
    logic [31:0] l_addr = '0, p_addr = '0, l_wd = '0, p_wd = '0;
    logic [3:0]  l_be = '0, p_be = '0;

    always #4 clk = ~clk;

    lsa_top dut_i (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .req_size, .req_write,
        .req_signed, .req_wdata, .policy, .mem_valid, .mem_addr, .mem_write,
        .mem_be, .mem_wdata, .mem_ready, .mem_rdata, .done, .fault, .rdata
    );

    function automatic logic [31:0] word_at(logic [31:0] a);
        logic [7:0] b = a[7:0] & 8'hFC;
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    assign mem_rdata = word_at(mem_addr);
    assign mem_ready = mem_valid && (stall_cnt >= stall_cfg);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid && !mem_ready) stall_cnt <= stall_cnt + 1;
        else                         stall_cnt <= 0;
        if (mem_valid && mem_ready) begin
            hs_total <= hs_total + 1;
            hs_cyc   <= cyc + 1;
            p_addr <= l_addr; p_be <= l_be; p_wd <= l_wd;
            l_addr <= mem_addr; l_be <= mem_be; l_wd <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid  = 1'b1;
        policy     = v.pol;
        req_size   = v.size;
        req_write  = v.wr;
        req_signed = v.sgn;
        req_addr   = v.addr;
        req_wdata  = v.wdata;
    endtask

    task automatic wait_done(output bit ok);
        int t = 0;
        while (!done && t < 60) begin
            @(negedge clk);
            t++;
        end
        ok = done;
        if (!ok) chk(1'b0, "R9 completion never arrived", 32'h0, 32'h1);
    endtask

    task automatic judge(input vec_t v, input int start);
        int nb = hs_total - start;
        logic [31:0] base = v.addr & ~32'h3;
        chk(fault == v.flt, "R4 fault flag", 32'(fault), 32'(v.flt));
        chk(nb == int'(v.nbeat), "R2/R3/R5 beat count", 32'(nb), 32'(v.nbeat));
        if (!v.wr) chk(rdata == v.rdata, "R6/R7 load result", rdata, v.rdata);
        if (!v.flt) chk(cyc == hs_cyc, "R9 done one cycle after last beat", 32'(cyc), 32'(hs_cyc));
        if (nb == int'(v.nbeat) && nb > 0) begin
            chk(((nb == 2) ? p_addr : l_addr) == base, "R5 first beat address",
                (nb == 2) ? p_addr : l_addr, base);
            chk(((nb == 2) ? p_be : l_be) == v.be0, "R8 byte enables first beat",
                32'((nb == 2) ? p_be : l_be), 32'(v.be0));
            if (v.wr) chk(((nb == 2) ? p_wd : l_wd) == v.wd0, "R8 write lanes first beat",
                          (nb == 2) ? p_wd : l_wd, v.wd0);
            if (nb == 2) begin
                chk(l_addr == base + 32'd4, "R5 second beat address", l_addr, base + 32'd4);
                chk(l_be == v.be1, "R8 byte enables second beat", 32'(l_be), 32'(v.be1));
                if (v.wr) chk(l_wd == v.wd1, "R8 write lanes second beat", l_wd, v.wd1);
            end
        end
    endtask

    task automatic run_vec(input vec_t v);
        int start = hs_total;
        bit ok;
        drive(v);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(ok);
        if (ok) judge(v, start);
        @(negedge clk);
    endtask

    task automatic idle_state(input string tag);
        chk(mem_valid == 1'b0, {tag, " mem_valid low"}, 32'(mem_valid), 32'h0);
        chk(done == 1'b0,      {tag, " done low"},      32'(done), 32'h0);
        chk(fault == 1'b0,     {tag, " fault low"},     32'(fault), 32'h0);
        chk(req_ready == 1'b1, {tag, " req_ready high"}, 32'(req_ready), 32'h1);
        chk(rdata == 32'h0,    {tag, " rdata zero"},    rdata, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit ok;
        int start;
        repeat (3) @(negedge clk);
        idle_state("R11 in reset");
        rst = 1'b0;
        @(negedge clk);
        idle_state("R11 after reset");

        // table pass with immediate memory, then with two wait states (R10)
        for (int pass = 0; pass < 2; pass++) begin
            stall_cfg = (pass == 0) ? 0 : 2;
            for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        end

        // R9: next request accepted in the same cycle as done
        stall_cfg = 1;
        drive(VECS[9]);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(ok);
        if (ok) begin
            chk(rdata == 32'hF9F8F7F6, "R9 first result during overlap", rdata, 32'hF9F8F7F6);
            start = hs_total;
            drive(VECS[1]);
            @(negedge clk);
            req_valid = 1'b0;
            chk(done == 1'b0 && mem_valid == 1'b1, "R9 overlapped request started",
                32'({done, mem_valid}), 32'h1);
            wait_done(ok);
            if (ok) begin
                chk(rdata == 32'hFFFFFFF5, "R9 overlapped request result", rdata, 32'hFFFFFFF5);
                chk(hs_total - start == 1 && l_addr == 32'h100000F4, "R9 overlapped beat address",
                    l_addr, 32'h100000F4);
            end
        end
        @(negedge clk);

        // R11: reset in the middle of a stalled split access
        stall_cfg = 3;
        drive(VECS[10]);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_valid == 1'b1, "R10 beat held under stall", 32'(mem_valid), 32'h1);
        rst = 1'b1;
        @(negedge clk);
        idle_state("R11 mid-access reset");
        rst = 1'b0;
        stall_cfg = 0;
        @(negedge clk);
        run_vec(VECS[0]);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule